// File: doc/BRIEF.md
# Local-to-Remote Write DMA Sequencer

This block controls one DMA channel. It copies a run of 32-bit words from the local system bus to a remote expansion bus. Software loads three values through a small register port: a remote start address, a local start address and a word count. A bit in the count register enables the channel. The block then splits the run into bursts. For each burst it does the following:

- It holds off the local slave port.
- It waits for the outbound data FIFO to drain.
- It asks for the shared local bus master and waits for the grant.
- It reads the burst's words into the data FIFO and then queues one write request.
- It releases the master and the slave lockout.
- It waits for the remote side to report that the write finished. Only then does it advance its addresses and reduce the remaining count.

When the count reaches zero, the enable bit clears and a sticky done flag sets. The done flag also drives the interrupt line.

The sequencer has six states:

| State | Meaning | Leaves when | Goes to |
|---|---|---|---|
| `ST_IDLE` | No transfer running | Enable is set with a non-zero count | `ST_LOCK` |
| | | Enable is set with a zero count | Stays in `ST_IDLE` and finishes at once |
| `ST_LOCK` | Slave retry asserted, waiting for the FIFO to drain | Data FIFO reports empty | `ST_ARB` |
| `ST_ARB` | Retry held, master requested | Grant arrives | `ST_LOAD` |
| `ST_LOAD` | One word moved per read acknowledge | Last word of the burst is acknowledged | `ST_POST` |
| `ST_POST` | One cycle that pushes the write request | Always after one cycle | `ST_WAIT` |
| `ST_WAIT` | Master and retry released, waiting for completion | Completion arrives and words remain | `ST_LOCK` |
| | | Completion arrives and no words remain | `ST_IDLE` and finishes |

Top module: `wr_dma_seq`

## Requirements
- R1: The register offsets are fixed. Offset 0 is the remote address, offset 1 the local address, offset 2 the length and offset 3 the status.
  - The length register holds the word count in bits [15:0] and the enable bit in bit 31.
  - The status register holds the done flag in bit 0.
  - Every register reads 0 after reset.
  - The address registers force bits [1:0] to zero on write, so addresses stay word aligned.
- R2: Writing the length register with bit 31 set starts a transfer. While enable is set, writes to offsets 0 to 2 are ignored.
- R3: Each burst asserts `slv_retry` first. `mst_req` rises only after `dfifo_empty` was seen high while the retry was held. `mst_req` never stands without `slv_retry`.
- R4: A word is pushed to the data FIFO only while `mst_gnt` is high. Each read acknowledge pushes exactly one word. The pushed word is the local word at address local start plus 4·k, for k = 0, 1, 2, …
- R5: A burst holds min(remaining, 8) words. After its last word, one `rq_push` carries the current remote address and that word count.
- R6: From the cycle after `rq_push` until the completion pulse, `slv_retry` and `mst_req` stay low.
- R7: The address and length registers change only in the cycle that `wr_done` arrives. At that point both addresses advance by 4 bytes per word of the burst, and the length drops by the burst size.
- R8: When the last burst completes:
  - the enable bit clears;
  - status bit 0 sets;
  - `irq` is high.
  - The final addresses equal the start addresses plus 4·count.
- R9: A zero count with enable set completes at once, pushes no data and queues no request.
- R10: Writing 1 to status bit 0 clears it and drops `irq`. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| slv_retry | output | 1 | Makes the local slave port retry all accesses |
| mst_req | output | 1 | Request for the shared local bus master |
| mst_gnt | input | 1 | Grant of the local bus master |
| lcl_rd_req | output | 1 | Local read request |
| lcl_rd_addr | output | 32 | Local read address |
| lcl_rd_ack | input | 1 | Local read data valid this cycle |
| lcl_rd_data | input | 32 | Local read data |
| dfifo_empty | input | 1 | Outbound data FIFO is empty |
| dfifo_push | output | 1 | Push strobe for the outbound data FIFO |
| dfifo_data | output | 32 | Word pushed into the data FIFO |
| rq_push | output | 1 | Push strobe for the write-request FIFO |
| rq_addr | output | 32 | Remote address of the burst |
| rq_words | output | 4 | Word count of the burst |
| wr_done | input | 1 | Remote write completion pulse |
| irq | output | 1 | Interrupt, equal to the done flag |

## Verification
If a state transition fires early, it shows at the ports within one burst. A master request would appear without a preceding empty FIFO, or a request would be pushed before all words of the burst were loaded. If a burst counter or address is wrong, the first wrong word pushed to the FIFO exposes it, because each word's data depends on its local address. The remote address and count of the next request are also checked. If the registers update at the wrong time, the length read back through the register port differs from the expected value within a cycle of the completion pulse. An update that was lost or doubled shows in the final addresses.

// File: rtl/wr_dma_pkg.sv
package wr_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK,
        ST_ARB,
        ST_LOAD,
        ST_POST,
        ST_WAIT
    } seq_state_t;

    localparam int REG_W     = 32;
    localparam int EN_BIT    = 31;
    localparam logic [1:0] OFS_RMT  = 2'd0;
    localparam logic [1:0] OFS_LCL  = 2'd1;
    localparam logic [1:0] OFS_LEN  = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

endpackage

// File: rtl/wr_dma_regs.sv
module wr_dma_regs
    import wr_dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 8,
    localparam int BCNT_W   = $clog2(MAX_BURST + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              upd_i,
    input  logic [BCNT_W-1:0] upd_words_i,
    input  logic              fin_i,
    output logic [ADDR_W-1:0] rmt_o,
    output logic [ADDR_W-1:0] lcl_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              en_o,
    output logic              done_o
);

    logic [ADDR_W-1:0] rmt_q, lcl_q;
    logic [LEN_W-1:0]  len_q;
    logic              en_q, done_q;
    logic [ADDR_W-1:0] step_bytes;
    logic              unused_wbits;

    assign step_bytes   = ADDR_W'(upd_words_i) << 2;
    assign unused_wbits = ^wdata_i[EN_BIT-1:LEN_W];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rmt_q  <= '0;
            lcl_q  <= '0;
            len_q  <= '0;
            en_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (wr_en_i && !en_q) begin
                unique case (addr_i)
                    OFS_RMT: rmt_q <= {wdata_i[ADDR_W-1:2], 2'b00};
                    OFS_LCL: lcl_q <= {wdata_i[ADDR_W-1:2], 2'b00};
                    OFS_LEN: begin
                        len_q <= wdata_i[LEN_W-1:0];
                        en_q  <= wdata_i[EN_BIT];
                    end
                    default: ;
                endcase
            end
            if (wr_en_i && addr_i == OFS_STAT && wdata_i[0]) begin
                done_q <= 1'b0;
            end
            if (upd_i) begin
                rmt_q <= rmt_q + step_bytes;
                lcl_q <= lcl_q + step_bytes;
                len_q <= len_q - LEN_W'(upd_words_i);
            end
            if (fin_i) begin
                en_q   <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_RMT: rdata_o[ADDR_W-1:0] = rmt_q;
            OFS_LCL: rdata_o[ADDR_W-1:0] = lcl_q;
            OFS_LEN: begin
                rdata_o[LEN_W-1:0] = len_q;
                rdata_o[EN_BIT]    = en_q;
            end
            default: rdata_o[0] = done_q;
        endcase
    end

    assign rmt_o  = rmt_q;
    assign lcl_o  = lcl_q;
    assign len_o  = len_q;
    assign en_o   = en_q;
    assign done_o = done_q;

    // R7: while a transfer runs, only a completion update may move the registers
    a_r7_regs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q && !upd_i) |=> (len_q == $past(len_q) && rmt_q == $past(rmt_q)
                              && lcl_q == $past(lcl_q)))
        else $error("R7 registers moved without completion");

    // R8: finishing clears enable and raises done
    a_r8_fin_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fin_i |=> (!en_q && done_q))
        else $error("R8 finish did not take effect");

endmodule

// File: rtl/wr_dma_fsm.sv
module wr_dma_fsm
    import wr_dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 8,
    localparam int BCNT_W   = $clog2(MAX_BURST + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] rmt_i,
    input  logic [ADDR_W-1:0] lcl_i,
    input  logic              dfifo_empty_i,
    input  logic              mst_gnt_i,
    input  logic              lcl_rd_ack_i,
    input  logic [DATA_W-1:0] lcl_rd_data_i,
    input  logic              wr_done_i,
    output logic              slv_retry_o,
    output logic              mst_req_o,
    output logic              lcl_rd_req_o,
    output logic [ADDR_W-1:0] lcl_rd_addr_o,
    output logic              dfifo_push_o,
    output logic [DATA_W-1:0] dfifo_data_o,
    output logic              rq_push_o,
    output logic [ADDR_W-1:0] rq_addr_o,
    output logic [BCNT_W-1:0] rq_words_o,
    output logic              upd_o,
    output logic [BCNT_W-1:0] upd_words_o,
    output logic              fin_o
);

    seq_state_t        state_q, state_d;
    logic [BCNT_W-1:0] wcnt_q;
    logic [BCNT_W-1:0] blen;
    logic              last_word;
    logic              last_burst;

    always_comb begin
        if (len_i > LEN_W'(MAX_BURST)) blen = BCNT_W'(MAX_BURST);
        else                           blen = len_i[BCNT_W-1:0];
    end

    assign last_word  = lcl_rd_ack_i && ((wcnt_q + BCNT_W'(1)) == blen);
    assign last_burst = (len_i == LEN_W'(blen));

    // state register and burst word counter
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_LOAD)  wcnt_q <= '0;
            else if (lcl_rd_ack_i)   wcnt_q <= wcnt_q + BCNT_W'(1);
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_i && len_i != '0) state_d = ST_LOCK;
            ST_LOCK: if (dfifo_empty_i)       state_d = ST_ARB;
            ST_ARB:  if (mst_gnt_i)           state_d = ST_LOAD;
            ST_LOAD: if (last_word)           state_d = ST_POST;
            ST_POST:                          state_d = ST_WAIT;
            ST_WAIT: if (wr_done_i)           state_d = last_burst ? ST_IDLE : ST_LOCK;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        slv_retry_o   = 1'b0;
        mst_req_o     = 1'b0;
        lcl_rd_req_o  = 1'b0;
        dfifo_push_o  = 1'b0;
        rq_push_o     = 1'b0;
        upd_o         = 1'b0;
        fin_o         = 1'b0;
        unique case (state_q)
            ST_IDLE: fin_o = en_i && (len_i == '0);
            ST_LOCK: slv_retry_o = 1'b1;
            ST_ARB: begin
                slv_retry_o = 1'b1;
                mst_req_o   = 1'b1;
            end
            ST_LOAD: begin
                slv_retry_o  = 1'b1;
                mst_req_o    = 1'b1;
                lcl_rd_req_o = 1'b1;
                dfifo_push_o = lcl_rd_ack_i;
            end
            ST_POST: begin
                slv_retry_o = 1'b1;
                mst_req_o   = 1'b1;
                rq_push_o   = 1'b1;
            end
            ST_WAIT: begin
                upd_o = wr_done_i;
                fin_o = wr_done_i && last_burst;
            end
            default: ;
        endcase
    end

    assign lcl_rd_addr_o = lcl_i + (ADDR_W'(wcnt_q) << 2);
    assign dfifo_data_o  = lcl_rd_data_i;
    assign rq_addr_o     = rmt_i;
    assign rq_words_o    = blen;
    assign upd_words_o   = blen;

    // R3: master request only follows a drained data FIFO
    a_r3_arb_after_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mst_req_o) |-> $past(dfifo_empty_i))
        else $error("R3 master requested before FIFO drained");

    // R4: no push without the master grant
    a_r4_push_has_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dfifo_push_o |-> mst_gnt_i)
        else $error("R4 push without grant");

    // R6: request push is followed by releasing master and retry
    a_r6_release_after_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rq_push_o |=> (!slv_retry_o && !mst_req_o))
        else $error("R6 master or retry held after request push");

endmodule

// File: rtl/wr_dma_seq.sv
module wr_dma_seq
    import wr_dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr_en,
    input  logic [1:0]                       reg_addr,
    input  logic [31:0]                      reg_wdata,
    output logic [31:0]                      reg_rdata,
    output logic                             slv_retry,
    output logic                             mst_req,
    input  logic                             mst_gnt,
    output logic                             lcl_rd_req,
    output logic [ADDR_W-1:0]                lcl_rd_addr,
    input  logic                             lcl_rd_ack,
    input  logic [DATA_W-1:0]                lcl_rd_data,
    input  logic                             dfifo_empty,
    output logic                             dfifo_push,
    output logic [DATA_W-1:0]                dfifo_data,
    output logic                             rq_push,
    output logic [ADDR_W-1:0]                rq_addr,
    output logic [$clog2(MAX_BURST+1)-1:0]   rq_words,
    input  logic                             wr_done,
    output logic                             irq
);

    localparam int BCNT_W = $clog2(MAX_BURST + 1);

    logic [ADDR_W-1:0] rmt, lcl;
    logic [LEN_W-1:0]  len;
    logic              en, done, upd, fin;
    logic [BCNT_W-1:0] upd_words;

    wr_dma_regs #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST)
    ) u_regs (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (reg_wr_en),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .rdata_o     (reg_rdata),
        .upd_i       (upd),
        .upd_words_i (upd_words),
        .fin_i       (fin),
        .rmt_o       (rmt),
        .lcl_o       (lcl),
        .len_o       (len),
        .en_o        (en),
        .done_o      (done)
    );

    wr_dma_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST)
    ) u_fsm (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .en_i          (en),
        .len_i         (len),
        .rmt_i         (rmt),
        .lcl_i         (lcl),
        .dfifo_empty_i (dfifo_empty),
        .mst_gnt_i     (mst_gnt),
        .lcl_rd_ack_i  (lcl_rd_ack),
        .lcl_rd_data_i (lcl_rd_data),
        .wr_done_i     (wr_done),
        .slv_retry_o   (slv_retry),
        .mst_req_o     (mst_req),
        .lcl_rd_req_o  (lcl_rd_req),
        .lcl_rd_addr_o (lcl_rd_addr),
        .dfifo_push_o  (dfifo_push),
        .dfifo_data_o  (dfifo_data),
        .rq_push_o     (rq_push),
        .rq_addr_o     (rq_addr),
        .rq_words_o    (rq_words),
        .upd_o         (upd),
        .upd_words_o   (upd_words),
        .fin_o         (fin)
    );

    assign irq = done;

endmodule

// File: tb/wr_dma_seq_tb.sv
module wr_dma_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int MB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        slv_retry, mst_req, lcl_rd_req, dfifo_push, rq_push, irq;
    logic        mst_gnt = 1'b0, lcl_rd_ack = 1'b0, dfifo_empty = 1'b0, wr_done = 1'b0;
    logic [31:0] lcl_rd_addr, lcl_rd_data = '0, dfifo_data, rq_addr;
    logic [3:0]  rq_words;

    wr_dma_seq #(.ADDR_W(AW), .DATA_W(32), .LEN_W(LW), .MAX_BURST(MB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slv_retry(slv_retry),
        .mst_req(mst_req), .mst_gnt(mst_gnt), .lcl_rd_req(lcl_rd_req),
        .lcl_rd_addr(lcl_rd_addr), .lcl_rd_ack(lcl_rd_ack), .lcl_rd_data(lcl_rd_data),
        .dfifo_empty(dfifo_empty), .dfifo_push(dfifo_push), .dfifo_data(dfifo_data),
        .rq_push(rq_push), .rq_addr(rq_addr), .rq_words(rq_words),
        .wr_done(wr_done), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_rmt, exp_push_addr;
    int exp_rem, cur_blen, pushed, reqs, burst_cnt, pend;
    bit len_watch = 0, waiting = 0, armed = 0, prev_mst = 0;

    function automatic logic [31:0] memf(logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic int burst_of(int rem);
        return (rem > MB) ? MB : rem;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2 v = reg_rdata;
        reg_addr = 2'd2;
    endtask

    // environment: local bus, FIFOs, arbiter and remote completion
    task automatic run_env();
        pend = -1;
        forever begin
            @(negedge clk);
            if (mst_req && !prev_mst)
                chk(armed, "R3", "mst_req rose without drained FIFO", 32'(mst_req), 32'(armed));
            if (mst_req)
                chk(slv_retry, "R3", "mst_req without slv_retry", 32'(slv_retry), 1);
            if (waiting)
                chk(!slv_retry && !mst_req, "R6", "held after request push",
                    {30'd0, slv_retry, mst_req}, 0);
            if (!slv_retry) armed = 0;
            prev_mst = mst_req;
            if (len_watch)
                chk(reg_rdata[LW-1:0] == LW'(exp_rem), "R7", "length register",
                    32'(reg_rdata[LW-1:0]), 32'(exp_rem));
            dfifo_empty = ($urandom % 3) == 0;
            mst_gnt     = mst_req && (mst_gnt || ($urandom % 3) == 0);
            lcl_rd_ack  = lcl_rd_req && (($urandom % 2) == 0);
            lcl_rd_data = memf(lcl_rd_addr);
            wr_done     = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin wr_done = 1'b1; pend = -1; end
            end
            #1;
            if (dfifo_push) begin
                chk(mst_gnt, "R4", "push without grant", 32'(mst_gnt), 1);
                chk(dfifo_data == memf(exp_push_addr), "R4", "pushed word",
                    dfifo_data, memf(exp_push_addr));
                exp_push_addr += 4; pushed++; burst_cnt++;
            end
            if (slv_retry && !mst_req && dfifo_empty) armed = 1;
            if (rq_push) begin
                chk(rq_addr == exp_rmt, "R5", "request address", rq_addr, exp_rmt);
                chk(32'(rq_words) == 32'(burst_of(exp_rem)), "R5", "request words",
                    32'(rq_words), 32'(burst_of(exp_rem)));
                chk(burst_cnt == burst_of(exp_rem), "R5", "words loaded before request",
                    32'(burst_cnt), 32'(burst_of(exp_rem)));
                cur_blen = burst_of(exp_rem); burst_cnt = 0; reqs++;
                pend = 1 + int'($urandom % 4); waiting = 1;
            end
            if (wr_done) begin
                exp_rmt += 32'(4 * cur_blen);
                exp_rem -= cur_blen;
                waiting = 0;
            end
        end
    endtask

    task automatic run_xfer(logic [31:0] rmt, logic [31:0] lcl, int n, bit poke);
        logic [31:0] v;
        string rq;
        bit got;
        rq = (n == 0) ? "R9" : "R8";
        exp_rmt = rmt; exp_push_addr = lcl; exp_rem = n;
        pushed = 0; reqs = 0; burst_cnt = 0;
        reg_write(2'd0, rmt);
        reg_write(2'd1, lcl);
        reg_write(2'd2, 32'h8000_0000 | 32'(n));
        len_watch = 1;
        if (poke) begin
            len_watch = 0;
            reg_write(2'd0, 32'hDEAD_BEE0);   // R2: ignored while enabled
            reg_write(2'd2, 32'h0000_0000);   // R2: must not stop the transfer
            @(negedge clk);
            len_watch = 1;
        end
        got = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (irq) begin got = 1; break; end
        end
        len_watch = 0;
        chk(got, rq, "transfer completion", 32'(got), 1);
        repeat (2) @(negedge clk);
        chk(pushed == n, (n == 0) ? "R9" : "R4", "words pushed", 32'(pushed), 32'(n));
        chk(reqs == (n + MB - 1) / MB, (n == 0) ? "R9" : "R5", "request count",
            32'(reqs), 32'((n + MB - 1) / MB));
        reg_read(2'd0, v);
        chk(v == rmt + 32'(4 * n), poke ? "R2" : "R7", "final remote address", v, rmt + 32'(4 * n));
        reg_read(2'd1, v);
        chk(v == lcl + 32'(4 * n), "R7", "final local address", v, lcl + 32'(4 * n));
        reg_read(2'd2, v);
        chk(v == 32'd0, rq, "length and enable after done", v, 0);
        reg_read(2'd3, v);
        chk(v == 32'd1, rq, "done flag", v, 1);
        chk(irq, rq, "irq after done", 32'(irq), 1);
        reg_write(2'd3, 32'd1);
        #2 chk(!irq, "R10", "irq after write-1 clear", 32'(irq), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork run_env(); join_none
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end
        chk(!slv_retry && !mst_req && !irq, "R1", "outputs after reset",
            {29'd0, slv_retry, mst_req, irq}, 0);
        // R1: alignment and length readback without enable
        reg_write(2'd0, 32'h1234_5677);
        reg_read(2'd0, v);
        chk(v == 32'h1234_5674, "R1", "remote address alignment", v, 32'h1234_5674);
        reg_write(2'd1, 32'h0000_0AB3);
        reg_read(2'd1, v);
        chk(v == 32'h0000_0AB0, "R1", "local address alignment", v, 32'h0000_0AB0);
        reg_write(2'd2, 32'd5);
        reg_read(2'd2, v);
        chk(v == 32'd5, "R1", "length readback", v, 5);
        repeat (5) @(negedge clk);
        chk(!slv_retry && !irq, "R2", "no start without enable", {30'd0, slv_retry, irq}, 0);
        reg_write(2'd2, 32'd0);
        // directed corners
        run_xfer(32'h8000_0000, 32'h0000_1000, 0, 0);  // R9
        run_xfer(32'h8000_0100, 32'h0000_2000, 8, 0);
        run_xfer(32'h8000_0200, 32'h0000_3000, 9, 0);
        run_xfer(32'h8000_0300, 32'h0000_4000, 1, 0);
        run_xfer(32'h8000_0400, 32'h0000_5000, 30, 1); // R2
        // R10: writing 0 keeps the flag
        run_xfer(32'h9000_0000, 32'h0001_0000, 3, 0);
        reg_write(2'd2, 32'h8000_0000);
        repeat (2) @(negedge clk);
        reg_write(2'd3, 32'd0);
        reg_read(2'd3, v);
        chk(v == 32'd1, "R10", "done kept after write 0", v, 1);
        reg_write(2'd3, 32'd1);
        // random transfers
        for (int t = 0; t < 10; t++) begin
            run_xfer($urandom & 32'hFFFF_FFFC, $urandom & 32'h00FF_FFFC,
                     1 + int'($urandom % 40), 0);
        end
        finish_run();
    end

endmodule